// File: doc/BRIEF.md
# Dual-Compare Programmable Timer

This block is a 16-bit up-counter that advances on a prescaler clock-enable pulse. It produces a square-wave or pulse-width-modulated output and two interrupt-factor pulses. Compare register B sets the period: the counter returns to zero on the tick after it matches B. Compare register A sets the duty point. In fine mode, compare A is matched against the counter extended by a half-step phase bit. This doubles the duty resolution and doubles the period.

Software programs the block through a single-cycle write strobe with an address and data. The control word holds the run bit, the mode select, the polarity bit and the output-enable bit. The two compare values each have their own address. The interrupt-factor pulses go to a separate flag and enable block, which is not part of this design.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every register reads as zero. The counter is stopped, both interrupt pulses are low, and the output is low, because the output enable is clear and the polarity bit is 0.
- R2: The counter, the output level and the interrupt pulses change only on a clock where `tick` is high and the run bit is 1. With `tick` low, nothing changes.
- R3: In normal mode the counter starts at 0 when the run bit is set. The compare-A pulse follows the (A+1)-th tick. The compare-B pulse follows the tick on which the counter equals B, and the counter wraps to 0 on that tick. The period is therefore B+1 ticks.
- R4: An internal level is set by a compare-A event and cleared by a compare-B event. With the polarity bit (control bit 2) at 1, the output equals this level: it rises on A and falls on B. With the polarity bit at 0, the output is the complement. With A=0 and B=1, the output period is two ticks.
- R5: In normal mode with A > B, no compare-A pulse is produced. The output stays at its off level, which is the level after a compare-B event.
- R6: When compare A and compare B match on the same tick, compare B wins: only the compare-B pulse appears and the level is cleared. The two pulses are never high together.
- R7: Fine mode (control bit 1) compares A against {counter, phase}. The phase bit toggles on every tick, and the counter steps when the phase is 1. The period is 2(B+1) ticks. Compare A never fires when A > 2B+1.
- R8: With the output-enable bit (control bit 3) at 0, the output equals the polarity bit. The counter and the interrupt pulses keep running.
- R9: A write to the mode bit while the run bit is 1 is ignored. The run, polarity and enable bits in the same write still take effect.
- R10: Address 0 holds the control word (bit 0 run, bit 1 fine, bit 2 polarity, bit 3 enable). Address 1 holds compare A and address 2 holds compare B. A write takes effect on the clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| tmr_out | output | 1 | Timer output clock |
| irq_cmp_a | output | 1 | Compare-A interrupt-factor pulse |
| irq_cmp_b | output | 1 | Compare-B interrupt-factor pulse |

## Verification
The counter, the level and both interrupt pulses update on the same edge that consumes a tick. The output is a combinational function of the registered level, so every result is due one edge after its tick. A register write is due one edge after its strobe. The bench drives inputs and samples outputs on the falling edge. After a run-start write, sample k reflects the k-th tick, and the expected pulse and high-level counts per window are fixed in the vector table. The start-phase test checks for the exact sample on which the first compare-A pulse appears.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          tmr_out,
  output logic          irq_cmp_a,
  output logic          irq_cmp_b
);
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_A    = 2'd1;
  localparam logic [1:0] ADR_B    = 2'd2;

  logic          run_q, fine_q, inv_q, en_q, lvl_q, ph_q;
  logic [CW-1:0] a_q, b_q, cnt_q;

  wire          step  = run_q & tick;
  wire [CW:0]   pos   = fine_q ? {cnt_q, ph_q} : {1'b0, cnt_q};
  wire          hit_b = step && (cnt_q == b_q) && (!fine_q || ph_q);
  wire          hit_a = step && (pos == {1'b0, a_q}) && !hit_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      fine_q <= 1'b0;
      inv_q  <= 1'b0;
      en_q   <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          run_q <= wr_data[0];
          inv_q <= wr_data[2];
          en_q  <= wr_data[3];
          if (!run_q) fine_q <= wr_data[1];
        end
        ADR_A:   a_q <= wr_data;
        ADR_B:   b_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else if (!run_q || hit_b) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else if (step) begin
      if (hit_a) lvl_q <= 1'b1;
      if (fine_q) begin
        ph_q <= ~ph_q;
        if (ph_q) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_cmp_a <= 1'b0;
      irq_cmp_b <= 1'b0;
    end else begin
      irq_cmp_a <= hit_a;
      irq_cmp_b <= hit_b;
    end
  end

  assign tmr_out = en_q ? (inv_q ? lvl_q : ~lvl_q) : inv_q;
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          run_q,
  input logic          fine_q,
  input logic          inv_q,
  input logic          en_q,
  input logic          ph_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] a_q,
  input logic [CW-1:0] b_q,
  input logic          tmr_out,
  input logic          irq_cmp_a,
  input logic          irq_cmp_b
);
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !tick |=> $stable(cnt_q) && !irq_cmp_a && !irq_cmp_b); // R2

  AST_WRAP_AT_B: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && tick && cnt_q == b_q && (!fine_q || ph_q) |=> cnt_q == '0 && irq_cmp_b); // R3

  AST_A_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp_a && en_q && inv_q && $stable(inv_q) && $stable(en_q) |-> tmr_out); // R4

  AST_B_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp_b && en_q && inv_q && $stable(inv_q) && $stable(en_q) |-> !tmr_out); // R4

  AST_NORM_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !fine_q && a_q > b_q |=> !irq_cmp_a); // R5

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_cmp_a && irq_cmp_b)); // R6

  AST_FINE_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && fine_q && {1'b0, a_q} > {b_q, 1'b1} |=> !irq_cmp_a); // R7

  AST_OFF_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> tmr_out == inv_q); // R8

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && wr_en && wr_addr == 2'd0 |=> $stable(fine_q)); // R9
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .run_q(run_q), .fine_q(fine_q), .inv_q(inv_q), .en_q(en_q), .ph_q(ph_q),
  .cnt_q(cnt_q), .a_q(a_q), .b_q(b_q), .tmr_out(tmr_out),
  .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b)
);

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tmr_out, irq_cmp_a, irq_cmp_b;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  dual_cmp_timer #(.CW(16)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmr_out(tmr_out), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        fine;
    logic        inv;
    logic [7:0]  ea;
    logic [7:0]  eb;
    logic [7:0]  eh;
  } vec_t;

  localparam int WIN = 48;
  localparam int NV  = 9;
  localparam vec_t VEC [NV] = '{
    '{16'd0, 16'd1, 1'b0, 1'b1, 8'd24, 8'd24, 8'd24},
    '{16'd2, 16'd5, 1'b0, 1'b1, 8'd8,  8'd8,  8'd24},
    '{16'd1, 16'd5, 1'b0, 1'b0, 8'd8,  8'd8,  8'd16},
    '{16'd7, 16'd3, 1'b0, 1'b1, 8'd0,  8'd12, 8'd0},
    '{16'd3, 16'd3, 1'b0, 1'b1, 8'd0,  8'd12, 8'd0},
    '{16'd5, 16'd3, 1'b1, 1'b1, 8'd6,  8'd6,  8'd12},
    '{16'd8, 16'd3, 1'b1, 1'b1, 8'd0,  8'd6,  8'd0},
    '{16'd0, 16'd2, 1'b1, 1'b0, 8'd8,  8'd8,  8'd8},
    '{16'd7, 16'd3, 1'b1, 1'b1, 8'd0,  8'd6,  8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] adr, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = adr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] b, input logic [15:0] ctrl);
    wr(2'd0, 16'h0008);
    wr(2'd1, a);
    wr(2'd2, b);
    wr(2'd0, ctrl);
  endtask

  task automatic window(input int n, output int na, output int nb, output int nh);
    na = 0; nb = 0; nh = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      na += int'(irq_cmp_a);
      nb += int'(irq_cmp_b);
      nh += int'(tmr_out);
    end
  endtask

  initial begin
    int na, nb, nh;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tmr_out == 1'b0, "R1 out", tmr_out, 0);
    chk(!irq_cmp_a && !irq_cmp_b, "R1 irq", irq_cmp_a | irq_cmp_b, 0);

    // vector table: R3 R4 R5 R6 R7 R10
    tick = 1'b1;
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v].a, VEC[v].b, {12'd0, 1'b1, VEC[v].inv, VEC[v].fine, 1'b1});
      window(WIN, na, nb, nh);
      chk(na == int'(VEC[v].ea), $sformatf("R5/R6/R7 vec%0d cmpA pulses", v), na, int'(VEC[v].ea));
      chk(nb == int'(VEC[v].eb), $sformatf("R3/R7 vec%0d cmpB pulses", v), nb, int'(VEC[v].eb));
      chk(nh == int'(VEC[v].eh), $sformatf("R4 vec%0d high samples", v), nh, int'(VEC[v].eh));
    end

    // R3 start phase: A=3,B=9, first cmpA after 4th tick, cmpB after 10th
    setup(16'd3, 16'd9, 16'h000D);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 4 || k == 3)
        chk(irq_cmp_a == (k == 4), $sformatf("R3 cmpA at tick %0d", k), irq_cmp_a, k == 4);
      if (k == 9 || k == 10)
        chk(irq_cmp_b == (k == 10), $sformatf("R3 cmpB at tick %0d", k), irq_cmp_b, k == 10);
    end

    // R2 no ticks: nothing moves
    tick = 1'b0;
    setup(16'd1, 16'd2, 16'h000D);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      bad += int'(irq_cmp_a | irq_cmp_b | tmr_out);
    end
    chk(bad == 0, "R2 idle without tick", bad, 0);
    // R2 sparse ticks: 9 ticks, period 3 ticks
    na = 0; nb = 0;
    for (int t = 0; t < 9; t++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      na += int'(irq_cmp_a); nb += int'(irq_cmp_b);
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        na += int'(irq_cmp_a); nb += int'(irq_cmp_b);
      end
    end
    chk(na == 3, "R2 sparse cmpA", na, 3);
    chk(nb == 3, "R2 sparse cmpB", nb, 3);

    // R8 output disabled with polarity 1: held high, pulses continue
    tick = 1'b1;
    setup(16'd0, 16'd1, 16'h0005);
    window(16, na, nb, nh);
    chk(nh == 16, "R8 fixed high", nh, 16);
    chk(nb == 8, "R8 cmpB continues", nb, 8);
    wr(2'd0, 16'h0001);
    window(4, na, nb, nh);
    chk(nh == 0, "R8 fixed low", nh, 0);

    // R9 fine bit ignored while running: period stays 6 ticks
    setup(16'd2, 16'd5, 16'h000D);
    wr(2'd0, 16'h000F);
    window(WIN, na, nb, nh);
    chk(nb == 8, "R9 mode write ignored", nb, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule